// File: doc/BRIEF.md
# Power-Fail Shutdown Sequencer

This block supervises the supply of a disk drive's motor drivers. It watches a supply-good level and, when that level drops while the drive is running, walks through a shutdown that cannot be interrupted. First the motor control registers are forced back to their reset values. Then the spindle power bridge is floated. Then the head actuator is driven to its parked position. Finally, after a programmable number of cycles, the spindle dynamic brake is applied. The block then stays latched in the parked-and-braked condition.

A power-up sequence guards the other direction, both after chip reset and when leaving the parked condition. The register-clear line stays asserted and the motor drivers stay disabled until the supply-good input has been high, without a single low sample, for a programmable number of cycles. The supply-good input is brought into the clock domain by a parameterised synchronizer. Every output is a plain control level for the register bank and the driver stages.

Top module: `pfail_seq`

## Requirements
- R1: While reset is asserted and during power-up settling, the outputs read drv_en=0, regs_clr=1, spin_hiz=1, retract=0, brake=0.
- R2: With supply_good held high, drv_en rises on clock edge SYNC_STAGES+SETTLE_CYC after reset release or after the supply rise. The bench uses SYNC_STAGES=2 and SETTLE_CYC=16. It is still low one edge earlier.
- R3: A single low sample of supply_good during settling restarts the settle count from zero.
- R4: In the running state only drv_en is high. regs_clr, spin_hiz, retract and brake are all low.
- R5: A supply_good drop seen while running asserts regs_clr alone on edge SYNC_STAGES+1 after the drop. spin_hiz, retract and brake stay low for that one cycle, and drv_en goes low.
- R6: One edge after regs_clr asserts, spin_hiz asserts while regs_clr stays high. retract is still low.
- R7: One edge after spin_hiz asserts, retract asserts.
- R8: brake asserts exactly RETRACT_CYC+BRAKE_DLY edges after retract asserts, and not earlier. The bench uses RETRACT_CYC=8 and BRAKE_DLY=12.
- R9: Once asserted during shutdown, regs_clr, spin_hiz, retract and brake stay asserted until the block next enters the running state.
- R10: supply_good returning high in the middle of a shutdown does not stop it. brake is still applied at the normal time.
- R11: The parked outputs (regs_clr, spin_hiz, retract, brake all high) hold until supply_good has been high for SETTLE_CYC consecutive samples. The block then goes straight to running.
- R12: drv_en is never high together with any of regs_clr, spin_hiz, retract or brake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_good | input | 1 | Supply-good level from the comparator, asynchronous |
| drv_en | output | 1 | Motor drivers enabled (running) |
| regs_clr | output | 1 | Hold motor control registers at reset values |
| spin_hiz | output | 1 | Float the spindle power bridge |
| retract | output | 1 | Drive the actuator toward the park position |
| brake | output | 1 | Apply the spindle dynamic brake |

## Verification
Every output is decoded from the state register, so each result is due a fixed number of edges after the input change. A supply transition reaches the state register on the third edge through the two synchronizer flops. The shutdown steps then follow on consecutive edges. The brake comes RETRACT_CYC+BRAKE_DLY edges after retract, and running is reached SETTLE_CYC edges after the first high sample. The driver tasks change supply_good on a falling edge and enqueue each expected output word with the exact edge count at which it is due, including the edge just before each transition. The monitor compares on the following falling edge, so every check lands inside the one cycle where the result is defined.

// File: rtl/pfail_pkg.sv
package pfail_pkg;

   typedef enum logic [2:0] {
      ST_SETTLE  = 3'd0,
      ST_RUN     = 3'd1,
      ST_CLR     = 3'd2,
      ST_HIZ     = 3'd3,
      ST_RETRACT = 3'd4,
      ST_BWAIT   = 3'd5,
      ST_PARKED  = 3'd6
   } pf_state_e;

   typedef struct packed {
      logic drv_en;
      logic regs_clr;
      logic spin_hiz;
      logic retract;
      logic brake;
   } pf_ctl_t;

endpackage

// File: rtl/pfail_sync.sv
module pfail_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else if (STAGES == 1) chain_q <= d_in;
            else chain_q <= {chain_q[STAGES-2:0], d_in};
         end
         assign q_out = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pfail_timer.sv
module pfail_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pfail_outdec.sv
module pfail_outdec
   import pfail_pkg::*;
(
   input  pf_state_e state,
   output pf_ctl_t   ctl
);
   always_comb begin
      ctl = '{drv_en: 1'b0, regs_clr: 1'b1, spin_hiz: 1'b1, retract: 1'b0, brake: 1'b0};
      case (state)
         ST_SETTLE:  ctl = '{drv_en: 1'b0, regs_clr: 1'b1, spin_hiz: 1'b1, retract: 1'b0, brake: 1'b0};
         ST_RUN:     ctl = '{drv_en: 1'b1, regs_clr: 1'b0, spin_hiz: 1'b0, retract: 1'b0, brake: 1'b0};
         ST_CLR:     ctl = '{drv_en: 1'b0, regs_clr: 1'b1, spin_hiz: 1'b0, retract: 1'b0, brake: 1'b0};
         ST_HIZ:     ctl = '{drv_en: 1'b0, regs_clr: 1'b1, spin_hiz: 1'b1, retract: 1'b0, brake: 1'b0};
         ST_RETRACT,
         ST_BWAIT:   ctl = '{drv_en: 1'b0, regs_clr: 1'b1, spin_hiz: 1'b1, retract: 1'b1, brake: 1'b0};
         ST_PARKED:  ctl = '{drv_en: 1'b0, regs_clr: 1'b1, spin_hiz: 1'b1, retract: 1'b1, brake: 1'b1};
         default:    ;
      endcase
   end
endmodule

// File: rtl/pfail_seq.sv
module pfail_seq
   import pfail_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE_CYC  = 16,
   parameter int RETRACT_CYC = 8,
   parameter int BRAKE_DLY   = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_good,
   output logic drv_en,
   output logic regs_clr,
   output logic spin_hiz,
   output logic retract,
   output logic brake
);
   localparam int MAX_A   = (SETTLE_CYC > RETRACT_CYC) ? SETTLE_CYC : RETRACT_CYC;
   localparam int MAX_LEN = (MAX_A > BRAKE_DLY) ? MAX_A : BRAKE_DLY;
   localparam int CNT_W   = $clog2(MAX_LEN + 1);
   localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
   localparam logic [CNT_W-1:0] RET_LAST    = CNT_W'(RETRACT_CYC - 1);
   localparam logic [CNT_W-1:0] BRK_LAST    = CNT_W'(BRAKE_DLY - 1);

   generate
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("pfail_seq: SYNC_STAGES must be non-negative");
      end
      if (SETTLE_CYC < 1 || RETRACT_CYC < 1 || BRAKE_DLY < 1) begin : g_bad_len
         $error("pfail_seq: every step length must be at least one cycle");
      end
   endgenerate

   logic             ok_s;
   logic             tmr_clr, tmr_inc;
   logic [CNT_W-1:0] tmr_cnt;
   pf_state_e        state_q, state_d;
   pf_ctl_t          ctl;

   pfail_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_in(supply_good), .q_out(ok_s)
   );

   pfail_timer #(.W(CNT_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(tmr_inc), .cnt(tmr_cnt)
   );

   always_comb begin
      state_d = state_q;
      tmr_clr = 1'b0;
      tmr_inc = 1'b0;
      case (state_q)
         ST_SETTLE, ST_PARKED: begin
            if (!ok_s) begin
               tmr_clr = 1'b1;
            end else if (tmr_cnt == SETTLE_LAST) begin
               state_d = ST_RUN;
               tmr_clr = 1'b1;
            end else begin
               tmr_inc = 1'b1;
            end
         end
         ST_RUN: begin
            tmr_clr = 1'b1;
            if (!ok_s) state_d = ST_CLR;
         end
         ST_CLR: begin
            tmr_clr = 1'b1;
            state_d = ST_HIZ;
         end
         ST_HIZ: begin
            tmr_clr = 1'b1;
            state_d = ST_RETRACT;
         end
         ST_RETRACT: begin
            if (tmr_cnt == RET_LAST) begin
               state_d = ST_BWAIT;
               tmr_clr = 1'b1;
            end else begin
               tmr_inc = 1'b1;
            end
         end
         ST_BWAIT: begin
            if (tmr_cnt == BRK_LAST) begin
               state_d = ST_PARKED;
               tmr_clr = 1'b1;
            end else begin
               tmr_inc = 1'b1;
            end
         end
         default: begin
            state_d = ST_CLR;
            tmr_clr = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_SETTLE;
      else        state_q <= state_d;
   end

   pfail_outdec i_outdec (.state(state_q), .ctl(ctl));

   assign drv_en   = ctl.drv_en;
   assign regs_clr = ctl.regs_clr;
   assign spin_hiz = ctl.spin_hiz;
   assign retract  = ctl.retract;
   assign brake    = ctl.brake;

endmodule

// File: rtl/pfail_seq_chk.sv
module pfail_seq_chk #(
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE_CYC  = 16,
   parameter int RETRACT_CYC = 8,
   parameter int BRAKE_DLY   = 12
) (
   input logic clk,
   input logic rst_n,
   input logic ok_s,
   input logic drv_en,
   input logic regs_clr,
   input logic spin_hiz,
   input logic retract,
   input logic brake
);
   int unsigned ret_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ret_cnt <= 0;
      else if (retract && !brake) ret_cnt <= ret_cnt + 1;
      else if (!retract)          ret_cnt <= 0;
   end

   p_settle_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!drv_en && !retract) |-> (regs_clr || !spin_hiz));

   p_run_needs_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_en) |-> $past(ok_s));

   p_drop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en && !ok_s) |=> (regs_clr && !spin_hiz && !retract && !brake));

   p_hiz_after_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spin_hiz) |-> $past(regs_clr));

   p_retract_after_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(retract) |-> ($past(spin_hiz) && $past(regs_clr)));

   p_brake_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brake) |-> (ret_cnt == RETRACT_CYC + BRAKE_DLY));

   p_retract_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(retract) |-> drv_en);

   p_brake_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(brake) |-> drv_en);

   p_hiz_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spin_hiz) |-> (drv_en || $past(drv_en)));

   p_drv_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> !(regs_clr || spin_hiz || retract || brake));

endmodule

bind pfail_seq pfail_seq_chk #(
   .SYNC_STAGES(SYNC_STAGES), .SETTLE_CYC(SETTLE_CYC),
   .RETRACT_CYC(RETRACT_CYC), .BRAKE_DLY(BRAKE_DLY)
) i_chk (.*);

// File: tb/test_pfail_seq.sv
`timescale 1ns/1ps
module test_pfail_seq;
   localparam int SY = 2;
   localparam int S  = 16;
   localparam int R  = 8;
   localparam int B  = 12;

   localparam logic [4:0] V_SETTLE = 5'b01100;
   localparam logic [4:0] V_RUN    = 5'b10000;
   localparam logic [4:0] V_CLR    = 5'b01000;
   localparam logic [4:0] V_HIZ    = 5'b01100;
   localparam logic [4:0] V_RET    = 5'b01110;
   localparam logic [4:0] V_PARK   = 5'b01111;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_good = 1'b1;
   logic drv_en, regs_clr, spin_hiz, retract, brake;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   int         q_at[$];
   logic [4:0] q_v[$];
   string      q_tag[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pfail_seq #(.SYNC_STAGES(SY), .SETTLE_CYC(S), .RETRACT_CYC(R), .BRAKE_DLY(B)) i_pfail_seq (
      .clk(clk), .rst_n(rst_n), .supply_good(supply_good),
      .drv_en(drv_en), .regs_clr(regs_clr), .spin_hiz(spin_hiz),
      .retract(retract), .brake(brake)
   );

   function automatic logic [4:0] outs();
      return {drv_en, regs_clr, spin_hiz, retract, brake};
   endfunction

   task automatic chk(input string tag, input logic [4:0] got, input logic [4:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: got %b expected %b", tag, cyc, got, exp);
      end
   endtask

   task automatic expect_at(input int at, input logic [4:0] v, input string tag);
      q_at.push_back(at);
      q_v.push_back(v);
      q_tag.push_back(tag);
   endtask

   always @(negedge clk) begin
      while (q_at.size() > 0 && q_at[0] <= cyc) begin
         if (q_at[0] < cyc) begin
            n_chk++;
            n_fail++;
            $display("FAIL %s: missed due cycle %0d (now %0d)", q_tag[0], q_at[0], cyc);
         end else begin
            chk(q_tag[0], outs(), q_v[0]);
         end
         void'(q_at.pop_front());
         void'(q_v.pop_front());
         void'(q_tag.pop_front());
      end
   end

   task automatic drain();
      while (q_at.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   // Shutdown from running; rise_after>0 brings the supply back mid-sequence (R10)
   task automatic shutdown(input int rise_after, input string tag);
      int base;
      int park;
      @(negedge clk);
      supply_good = 1'b0;
      base = cyc;
      park = base + SY + 3 + R + B;
      expect_at(base + SY,         V_RUN,  {tag, " R5 still running"});
      expect_at(base + SY + 1,     V_CLR,  {tag, " R5 clear alone"});
      expect_at(base + SY + 2,     V_HIZ,  {tag, " R6 bridge floated"});
      expect_at(base + SY + 3,     V_RET,  {tag, " R7 retract"});
      expect_at(park - 1,          V_RET,  {tag, " R8 no early brake"});
      expect_at(park,              V_PARK, {tag, " R8 brake applied"});
      if (rise_after > 0) begin
         repeat (rise_after) @(negedge clk);
         supply_good = 1'b1;
         expect_at(park + S - 1,   V_PARK, {tag, " R11 parked while settling"});
         expect_at(park + S,       V_RUN,  {tag, " R10 R11 back to running"});
      end else begin
         expect_at(park + 20,      V_PARK, {tag, " R9 R11 park held"});
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : stim
      int base;
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", outs(), V_SETTLE);
      rst_n = 1'b1;
      base = cyc;
      expect_at(base + 1,      V_SETTLE, "R1 settling outputs");
      expect_at(base + SY + S - 1, V_SETTLE, "R2 not yet running");
      expect_at(base + SY + S, V_RUN,    "R2 running after settle");
      expect_at(base + SY + S + 5, V_RUN, "R4 running outputs");
      drain();

      // plain shutdown, supply stays low
      shutdown(0, "plain");
      drain();

      // recovery with a one-cycle glitch in the settle window (R3)
      @(negedge clk);
      supply_good = 1'b1;
      base = cyc;
      repeat (5) @(negedge clk);
      supply_good = 1'b0;
      @(negedge clk);
      supply_good = 1'b1;
      expect_at(base + SY + 6 + S - 1, V_PARK, "R3 restart holds park");
      expect_at(base + SY + 6 + S,     V_RUN,  "R3 running after restart");
      drain();

      // supply returns during shutdown: no abort
      shutdown(4, "bounce");
      drain();
      chk("R12 running exclusive", outs(), V_RUN);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule